// File: doc/BRIEF.md
# Phase-Shifted Boost Modulator for Two Cascaded Full Bridges

This block produces the eight gate signals for two cascaded full-bridge modules, each fed by a switched-boost network. It runs two triangle carriers a quarter period apart. Every leg of both bridges is tied to one of these carriers. A signed reference sets how long each leg's high-side switch conducts. Module B uses the inverted reference, so the two bridge outputs are in anti-phase and their difference forms the five-level output.

To raise the capacitor voltage of a module, the block inserts shoot-through intervals. These are windows near each carrier extreme in which both switches of a leg conduct together. The window width comes from a per-module unsigned threshold, so an outer control loop can give the two modules different boost duties and keep their capacitors balanced. Each leg gives two shoot-through events per carrier period, so each module sees four. All inputs are captured only at a carrier peak, so an edge never moves in the middle of a carrier period.

Top module: `pspwm_cascade`

## Requirements
- R1: Carrier 0 is a triangle counter that starts at 0 counting up, climbs by 1 per clock to PERIOD, then falls by 1 per clock to 0, and repeats with a period of 2*PERIOD clocks. Carrier 1 follows the same path but starts at PERIOD/2 counting up. Both restart in this phase whenever reset is held or `run_en` is low.
- R2: The reference level is PERIOD/2 + ref. Outside a shoot-through window a leg's high-side gate is on when its level is strictly greater than its carrier, and its low-side gate is the complement. Gate bits are [0]/[1] high/low of leg 1 (carrier 0, +ref), [2]/[3] leg 2 (carrier 1, -ref), [4]/[5] leg 3 (carrier 0, -ref), and [6]/[7] leg 4 (carrier 1, +ref).
- R3: Module B (gate bits 4 to 7) uses the reference negated relative to module A on each carrier, which is a 180 degree shift.
- R4: A leg is in shoot-through, with both of its gates on, when its carrier is below the threshold or above PERIOD minus the threshold. Legs 1 and 2 use `boost_a_i`, legs 3 and 4 use `boost_b_i`, and thresholds above PERIOD/2 act as PERIOD/2.
- R5: With a non-zero threshold and steady inputs, each module shows exactly four shoot-through events (rising edges of a leg's both-on state) in every 2*PERIOD clocks.
- R6: A zero threshold for a module produces no both-on state on either of its legs.
- R7: Each carrier's legs use the reference and the two thresholds captured at the clock edge where that carrier equals PERIOD. Input changes at other times have no effect until that carrier's next peak.
- R8: Gates are registered. A gate after a clock edge reflects the carrier value before that edge. Reset or `run_en` low at an edge drives all eight gates low after it. While `run_en` is low the capture registers follow the inputs. Reset clears them to reference 0 and threshold 0.
- R9: The reference level saturates to the range 0 to PERIOD, so a reference beyond plus or minus PERIOD/2 pins the leg at full or zero duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Modulator run enable; low forces all gates off |
| ref_i | input | REF_W | Signed modulating reference, two's complement |
| boost_a_i | input | TH_W | Unsigned shoot-through threshold for module A |
| boost_b_i | input | TH_W | Unsigned shoot-through threshold for module B |
| gate_o | output | 8 | Gate drives, two per leg, legs 1 to 4 |

## Verification
The assertions assume that PERIOD is even. They also assume `run_en` and reset are sampled only at clock edges, so the carriers restart in a known phase and the capture registers change only at a peak or while the block is idle. The zero-threshold checks compare against the captured thresholds, not the live inputs, because the inputs may change at any cycle. The stimulus changes the reference and thresholds at points that are not aligned to a peak. It drives values past saturation and past the threshold clamp, and it drops `run_en` and reset in mid-period. A cycle-accurate reference model in the bench tracks the expected capture point for each case.

// File: rtl/pspwm_pkg.sv
package pspwm_pkg;

   localparam int PSPWM_CARRIERS = 2;
   localparam int PSPWM_LEGS     = 4;
   localparam int PSPWM_GATES    = 2 * PSPWM_LEGS;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dir_e;

endpackage

// File: rtl/pspwm_carrier.sv
module pspwm_carrier #(
   parameter int PERIOD = 2500,
   parameter int CNT_W  = 12,
   parameter int START  = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [CNT_W-1:0] cnt_o,
   output logic             peak_o
);

   localparam logic [CNT_W-1:0] TOP   = CNT_W'(PERIOD);
   localparam logic [CNT_W-1:0] SEED  = CNT_W'(START);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   pspwm_pkg::dir_e dir_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         cnt_q <= SEED;
         dir_q <= pspwm_pkg::DIR_UP;
      end else if (dir_q == pspwm_pkg::DIR_UP) begin
         if (cnt_q == TOP) begin
            cnt_q <= TOP - ONE;
            dir_q <= pspwm_pkg::DIR_DOWN;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
      end else begin
         if (cnt_q == '0) begin
            cnt_q <= ONE;
            dir_q <= pspwm_pkg::DIR_UP;
         end else begin
            cnt_q <= cnt_q - ONE;
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign peak_o = (cnt_q == TOP);

endmodule

// File: rtl/pspwm_capture.sv
module pspwm_capture #(
   parameter int PERIOD = 2500,
   parameter int CNT_W  = 12,
   parameter int REF_W  = 12,
   parameter int TH_W   = 11
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic                    peak_i,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic        [TH_W-1:0]  th_a_i,
   input  logic        [TH_W-1:0]  th_b_i,
   output logic        [CNT_W-1:0] lvl_pos_o,
   output logic        [CNT_W-1:0] lvl_neg_o,
   output logic        [CNT_W-1:0] th_a_o,
   output logic        [CNT_W-1:0] th_b_o
);

   localparam int SW = ((REF_W > CNT_W) ? REF_W : CNT_W) + 2;
   localparam int TW = ((TH_W > CNT_W) ? TH_W : CNT_W) + 1;
   localparam logic [CNT_W-1:0] MID = CNT_W'(PERIOD / 2);

   function automatic logic [CNT_W-1:0] sat_level(input logic signed [SW-1:0] v);
      logic [CNT_W-1:0] r;
      if (v < 0)
         r = '0;
      else if (v > SW'(PERIOD))
         r = CNT_W'(PERIOD);
      else
         r = v[CNT_W-1:0];
      return r;
   endfunction

   function automatic logic [CNT_W-1:0] sat_thresh(input logic [TH_W-1:0] t);
      logic [TW-1:0]    tx;
      logic [CNT_W-1:0] r;
      tx = TW'(t);
      if (tx > TW'(PERIOD / 2))
         r = MID;
      else
         r = tx[CNT_W-1:0];
      return r;
   endfunction

   logic signed [SW-1:0] ref_x;
   logic signed [SW-1:0] mid_x;
   logic signed [SW-1:0] pos_x;
   logic signed [SW-1:0] neg_x;
   logic                 load;

   assign ref_x = SW'(ref_i);
   assign mid_x = SW'(PERIOD / 2);
   assign pos_x = mid_x + ref_x;
   assign neg_x = mid_x - ref_x;
   assign load  = !en || peak_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_pos_o <= MID;
         lvl_neg_o <= MID;
         th_a_o    <= '0;
         th_b_o    <= '0;
      end else if (load) begin
         lvl_pos_o <= sat_level(pos_x);
         lvl_neg_o <= sat_level(neg_x);
         th_a_o    <= sat_thresh(th_a_i);
         th_b_o    <= sat_thresh(th_b_i);
      end
   end

endmodule

// File: rtl/pspwm_leg.sv
module pspwm_leg #(
   parameter int PERIOD = 2500,
   parameter int CNT_W  = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] carr_i,
   input  logic [CNT_W-1:0] lvl_i,
   input  logic [CNT_W-1:0] th_i,
   output logic             hi_o,
   output logic             lo_o
);

   logic [CNT_W:0] reach;
   logic           in_window;
   logic           above;

   assign reach     = {1'b0, carr_i} + {1'b0, th_i};
   assign in_window = (carr_i < th_i) || (reach > (CNT_W + 1)'(PERIOD));
   assign above     = (lvl_i > carr_i);

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         hi_o <= 1'b0;
         lo_o <= 1'b0;
      end else begin
         hi_o <= above | in_window;
         lo_o <= ~above | in_window;
      end
   end

endmodule

// File: rtl/pspwm_cascade.sv
module pspwm_cascade #(
   parameter int PERIOD = 2500,
   parameter int REF_W  = 12,
   parameter int TH_W   = 11
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    run_en,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic        [TH_W-1:0]  boost_a_i,
   input  logic        [TH_W-1:0]  boost_b_i,
   output logic        [7:0]       gate_o
);

   localparam int NC    = pspwm_pkg::PSPWM_CARRIERS;
   localparam int NL    = pspwm_pkg::PSPWM_LEGS;
   localparam int CNT_W = $clog2(PERIOD + 1);

   if (PERIOD < 4 || (PERIOD % 2) != 0) begin : g_bad_period
      $error("pspwm_cascade: PERIOD must be even and at least 4");
   end
   if (REF_W < 2) begin : g_bad_ref
      $error("pspwm_cascade: REF_W must be at least 2");
   end
   if (TH_W < 1) begin : g_bad_th
      $error("pspwm_cascade: TH_W must be at least 1");
   end
   if (pspwm_pkg::PSPWM_GATES != 8) begin : g_bad_gates
      $error("pspwm_cascade: gate count must be 8");
   end

   logic [CNT_W-1:0] carr    [NC];
   logic             peak    [NC];
   logic [CNT_W-1:0] lvl_pos [NC];
   logic [CNT_W-1:0] lvl_neg [NC];
   logic [CNT_W-1:0] th_a    [NC];
   logic [CNT_W-1:0] th_b    [NC];
   logic [NL-1:0]    hi_w;
   logic [NL-1:0]    lo_w;

   for (genvar k = 0; k < NC; k++) begin : g_carrier
      localparam int START = (k == 0) ? 0 : PERIOD / 2;

      pspwm_carrier #(
         .PERIOD (PERIOD),
         .CNT_W  (CNT_W),
         .START  (START)
      ) u_carr (
         .clk    (clk),
         .rst    (rst),
         .en     (run_en),
         .cnt_o  (carr[k]),
         .peak_o (peak[k])
      );

      pspwm_capture #(
         .PERIOD (PERIOD),
         .CNT_W  (CNT_W),
         .REF_W  (REF_W),
         .TH_W   (TH_W)
      ) u_cap (
         .clk       (clk),
         .rst       (rst),
         .en        (run_en),
         .peak_i    (peak[k]),
         .ref_i     (ref_i),
         .th_a_i    (boost_a_i),
         .th_b_i    (boost_b_i),
         .lvl_pos_o (lvl_pos[k]),
         .lvl_neg_o (lvl_neg[k]),
         .th_a_o    (th_a[k]),
         .th_b_o    (th_b[k])
      );
   end

   for (genvar i = 0; i < NL; i++) begin : g_leg
      localparam int K    = i % NC;
      localparam bit NEG  = (i == 1) || (i == 2);
      localparam bit MODB = (i >= 2);

      logic [CNT_W-1:0] lvl_sel;
      logic [CNT_W-1:0] th_sel;

      if (NEG) begin : g_neg
         assign lvl_sel = lvl_neg[K];
      end else begin : g_pos
         assign lvl_sel = lvl_pos[K];
      end

      if (MODB) begin : g_mod_b
         assign th_sel = th_b[K];
      end else begin : g_mod_a
         assign th_sel = th_a[K];
      end

      pspwm_leg #(
         .PERIOD (PERIOD),
         .CNT_W  (CNT_W)
      ) u_leg (
         .clk    (clk),
         .rst    (rst),
         .en     (run_en),
         .carr_i (carr[K]),
         .lvl_i  (lvl_sel),
         .th_i   (th_sel),
         .hi_o   (hi_w[i]),
         .lo_o   (lo_w[i])
      );

      assign gate_o[2*i]     = hi_w[i];
      assign gate_o[2*i + 1] = lo_w[i];
   end

endmodule

// File: rtl/pspwm_cascade_chk.sv
module pspwm_cascade_chk #(
   parameter int PERIOD = 2500,
   parameter int CNT_W  = 12
) (
   input logic             clk,
   input logic             rst,
   input logic             run_en,
   input logic [7:0]       gate_o,
   input logic [CNT_W-1:0] carr0,
   input logic [CNT_W-1:0] carr1,
   input logic [CNT_W-1:0] lvlp0,
   input logic [CNT_W-1:0] lvln0,
   input logic [CNT_W-1:0] tha0,
   input logic [CNT_W-1:0] thb0,
   input logic [CNT_W-1:0] lvlp1,
   input logic [CNT_W-1:0] lvln1,
   input logic [CNT_W-1:0] tha1,
   input logic [CNT_W-1:0] thb1
);

   localparam logic [CNT_W-1:0] TOP  = CNT_W'(PERIOD);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(PERIOD / 2);

   p_rst_clears_r8: assert property (@(posedge clk)
      rst |=> (gate_o == 8'h00));

   p_idle_clears_r8: assert property (@(posedge clk) disable iff (rst)
      !run_en |=> (gate_o == 8'h00));

   p_carrier_bound_r1: assert property (@(posedge clk) disable iff (rst)
      run_en |-> (carr0 <= TOP) && (carr1 <= TOP));

   p_carrier_step_r1: assert property (@(posedge clk) disable iff (rst)
      run_en |=> ((carr0 == $past(carr0) + 1'b1) || (carr0 == $past(carr0) - 1'b1)) &&
                 ((carr1 == $past(carr1) + 1'b1) || (carr1 == $past(carr1) - 1'b1)));

   p_quadrature_r1: assert property (@(posedge clk) disable iff (rst)
      ((carr0 == '0) || (carr0 == TOP)) |-> (carr1 == HALF));

   p_leg_never_open_r2: assert property (@(posedge clk) disable iff (rst)
      run_en |=> (gate_o[0] | gate_o[1]) && (gate_o[2] | gate_o[3]) &&
                 (gate_o[4] | gate_o[5]) && (gate_o[6] | gate_o[7]));

   p_no_boost_a_r6: assert property (@(posedge clk) disable iff (rst)
      (run_en && tha0 == '0 && tha1 == '0) |=>
         !(gate_o[0] & gate_o[1]) && !(gate_o[2] & gate_o[3]));

   p_no_boost_b_r6: assert property (@(posedge clk) disable iff (rst)
      (run_en && thb0 == '0 && thb1 == '0) |=>
         !(gate_o[4] & gate_o[5]) && !(gate_o[6] & gate_o[7]));

   p_hold_carrier0_r7: assert property (@(posedge clk) disable iff (rst)
      (run_en && carr0 != TOP) |=> $stable({lvlp0, lvln0, tha0, thb0}));

   p_hold_carrier1_r7: assert property (@(posedge clk) disable iff (rst)
      (run_en && carr1 != TOP) |=> $stable({lvlp1, lvln1, tha1, thb1}));

   p_thresh_clamp_r4: assert property (@(posedge clk) disable iff (rst)
      (tha0 <= HALF) && (thb0 <= HALF) && (tha1 <= HALF) && (thb1 <= HALF));

   p_level_range_r9: assert property (@(posedge clk) disable iff (rst)
      (lvlp0 <= TOP) && (lvln0 <= TOP) && (lvlp1 <= TOP) && (lvln1 <= TOP));

endmodule

bind pspwm_cascade pspwm_cascade_chk #(
   .PERIOD (PERIOD),
   .CNT_W  (CNT_W)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .run_en (run_en),
   .gate_o (gate_o),
   .carr0  (carr[0]),
   .carr1  (carr[1]),
   .lvlp0  (lvl_pos[0]),
   .lvln0  (lvl_neg[0]),
   .tha0   (th_a[0]),
   .thb0   (th_b[0]),
   .lvlp1  (lvl_pos[1]),
   .lvln1  (lvl_neg[1]),
   .tha1   (th_a[1]),
   .thb1   (th_b[1])
);

// File: tb/sim_pspwm_cascade.sv
module sim_pspwm_cascade;

   localparam int PER   = 64;
   localparam int REF_W = 10;
   localparam int TH_W  = 8;

   typedef struct {
      logic [7:0] g;
      string      tag;
   } sb_t;

   logic                    clk = 1'b0;
   logic                    rst;
   logic                    run_en;
   logic signed [REF_W-1:0] ref_i;
   logic        [TH_W-1:0]  boost_a_i;
   logic        [TH_W-1:0]  boost_b_i;
   logic        [7:0]       gate_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   sb_t q[$];

   int mc[2];
   bit mup[2];
   int lr[2];
   int la[2];
   int lb[2];

   always #2 clk = ~clk;

   pspwm_cascade #(
      .PERIOD (PER),
      .REF_W  (REF_W),
      .TH_W   (TH_W)
   ) u0 (
      .clk       (clk),
      .rst       (rst),
      .run_en    (run_en),
      .ref_i     (ref_i),
      .boost_a_i (boost_a_i),
      .boost_b_i (boost_b_i),
      .gate_o    (gate_o)
   );

   function automatic int clampi(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic logic [7:0] model_gates();
      logic [7:0] g;
      g = '0;
      for (int i = 0; i < 4; i++) begin
         int k;
         int r;
         int lvl;
         int th;
         int c;
         bit top;
         bit st;
         k   = i % 2;
         r   = ((i == 1) || (i == 2)) ? -lr[k] : lr[k];
         lvl = clampi(PER / 2 + r, 0, PER);
         th  = clampi((i < 2) ? la[k] : lb[k], 0, PER / 2);
         c   = mc[k];
         top = (lvl > c);
         st  = (c < th) || (c > PER - th);
         g[2*i]     = top | st;
         g[2*i + 1] = !top | st;
      end
      return g;
   endfunction

   task automatic model_edge();
      if (rst || !run_en) begin
         mc[0] = 0;  mc[1] = PER / 2;
         mup[0] = 1'b1; mup[1] = 1'b1;
         for (int k = 0; k < 2; k++) begin
            lr[k] = rst ? 0 : int'(ref_i);
            la[k] = rst ? 0 : int'(boost_a_i);
            lb[k] = rst ? 0 : int'(boost_b_i);
         end
      end else begin
         for (int k = 0; k < 2; k++) begin
            if (mc[k] == PER) begin
               lr[k] = int'(ref_i);
               la[k] = int'(boost_a_i);
               lb[k] = int'(boost_b_i);
            end
            if (mup[k]) begin
               if (mc[k] == PER) begin mc[k] = PER - 1; mup[k] = 1'b0; end
               else mc[k] = mc[k] + 1;
            end else begin
               if (mc[k] == 0) begin mc[k] = 1; mup[k] = 1'b1; end
               else mc[k] = mc[k] - 1;
            end
         end
      end
   endtask

   // driver: expected value for the coming edge, then advance one cycle
   task automatic step(input string tag);
      sb_t it;
      it.g   = (rst || !run_en) ? 8'h00 : model_gates();
      it.tag = tag;
      q.push_back(it);
      model_edge();
      @(negedge clk);
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   function automatic logic [3:0] overlaps();
      logic [3:0] o;
      for (int i = 0; i < 4; i++) o[i] = gate_o[2*i] & gate_o[2*i + 1];
      return o;
   endfunction

   task automatic measure(input int exp_a, input int exp_b, input string tag);
      logic [3:0] prev;
      logic [3:0] cur;
      int         cnt_a;
      int         cnt_b;
      cnt_a = 0;
      cnt_b = 0;
      prev  = overlaps();
      for (int n = 0; n < 2 * PER; n++) begin
         step(tag);
         cur = overlaps();
         for (int i = 0; i < 4; i++) begin
            if (cur[i] && !prev[i]) begin
               if (i < 2) cnt_a++;
               else cnt_b++;
            end
         end
         prev = cur;
      end
      n_chk++;
      if (cnt_a != exp_a) begin
         n_bad++;
         $display("FAIL %s module A shoot-through events: got %0d expected %0d", tag, cnt_a, exp_a);
      end
      n_chk++;
      if (cnt_b != exp_b) begin
         n_bad++;
         $display("FAIL %s module B shoot-through events: got %0d expected %0d", tag, cnt_b, exp_b);
      end
   endtask

   // monitor: compare each produced gate word with the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            sb_t it;
            it = q.pop_front();
            n_chk++;
            if (gate_o !== it.g) begin
               n_bad++;
               $display("FAIL %s: gate_o=%b expected %b at %0t", it.tag, gate_o, it.g, $time);
            end
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst       = 1'b1;
      run_en    = 1'b0;
      ref_i     = '0;
      boost_a_i = '0;
      boost_b_i = '0;
      mc[0] = 0; mc[1] = PER / 2;
      mup[0] = 1'b1; mup[1] = 1'b1;
      for (int k = 0; k < 2; k++) begin lr[k] = 0; la[k] = 0; lb[k] = 0; end
      @(negedge clk);

      run(3, "R8 reset");
      rst = 1'b0;
      ref_i = 10'sd100; boost_a_i = 8'd6; boost_b_i = 8'd3;
      run(2, "R8 disabled");

      // steady modulation with distinct boost per module
      run_en = 1'b1;
      run(4 * PER, "R1 R2 R3 R4 steady");
      measure(4, 4, "R5 four events");

      // input change away from any peak
      run(37, "R7 pre-change");
      ref_i = -10'sd150; boost_a_i = 8'd10; boost_b_i = 8'd1;
      run(3 * PER, "R7 capture at peak");
      measure(4, 4, "R5 after change");

      // zero thresholds: plain phase-shifted PWM
      ref_i = 10'sd40; boost_a_i = 8'd0; boost_b_i = 8'd0;
      run(3 * PER, "R6 no boost");
      measure(0, 0, "R6 no events");

      // one module boosted, the other not
      boost_b_i = 8'd5;
      run(3 * PER, "R4 R6 mixed");
      measure(0, 4, "R5 R6 mixed events");

      // saturation of reference and threshold clamp
      ref_i = 10'sd300; boost_a_i = 8'd200; boost_b_i = 8'd33;
      run(3 * PER, "R9 R4 saturate high");
      measure(4, 4, "R5 clamped threshold");
      ref_i = -10'sd500; boost_a_i = 8'd2;
      run(3 * PER, "R9 saturate low");

      // disable mid-period, then restart phase
      run(21, "R8 before drop");
      run_en = 1'b0;
      ref_i = 10'sd7; boost_a_i = 8'd4; boost_b_i = 8'd9;
      run(5, "R8 enable low");
      run_en = 1'b1;
      run(3 * PER, "R1 R8 restart");

      // reset mid-run
      run(11, "R8 before reset");
      rst = 1'b1;
      run(2, "R8 reset mid-run");
      rst = 1'b0;
      run(3 * PER, "R2 R8 after reset");

      @(posedge clk);
      #2;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule